// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Packet Tags

This block sits between an HDLC receive deframer and a host register interface. The deframer hands over one byte per clock with three tag bits. The tags mark the first byte of a frame, the last byte of a frame, and, on the last byte, whether the frame passed its checks. The block stores the byte and its tags together in a first-in first-out queue. The head entry and an empty indication are shown on the host side at all times. The host reads them as its status read, looks at the tags, and then pops the byte with a separate strobe. When the last byte of a frame arrives with its good-frame tag clear, the host discards everything it has gathered for that frame.

Four sticky event bits record frame start, frame end, the queue becoming non-empty and the queue reaching half occupancy. A write mask register gates each event onto an active-low interrupt line. Reading the event bits clears them.

An occupancy state machine produces the two level-based events. It has three states:
- `OC_EMPTY`: no entries.
- `OC_PART`: 1 to half-minus-one entries.
- `OC_HALF`: half or more entries.

Its transitions are:
- `OC_EMPTY→OC_PART`: raises the non-empty event.
- `OC_PART→OC_HALF`: raises the half-full event.
- `OC_HALF→OC_PART` and `OC_PART→OC_EMPTY`: silent.
- Self-loops: silent.

Top module: `hdlc_rx_tagfifo`

## Requirements
- R1: A synchronous active-high `rst` empties the queue (`fifo_empty`=1), clears all event bits and the overrun bit, and sets all four mask bits to 1 (masked), so `irq_n`=1.
- R2: Bytes leave in the order they were accepted. The queue holds 64 entries. `hd_data` shows the head entry combinationally, and `pop_rd` removes it at the next clock edge.
- R3: Each entry stores its tags with its byte: `hd_open`=first byte of a frame, `hd_close`=last byte of a frame, `hd_ok`=1 if the frame ending on that byte is to be kept. The head shows these tags together with its byte.
- R4: `fifo_empty`=1 exactly when no entry is held. While empty, `hd_data` and all head tags read 0, and `pop_rd` changes nothing.
- R5: A write while 64 entries are held is dropped and sets the sticky `ovr_flag`. `ovr_flag` clears on `ev_rd`.
- R6: Event bit 0 (frame start) sets at the edge that accepts a byte whose open tag is 1. Event bit 1 (frame end) sets at the edge that accepts a byte whose close tag is 1.
- R7: Event bit 2 (not empty) sets one clock after occupancy goes from 0 to 1 (`OC_EMPTY→OC_PART`).
- R8: Event bit 3 (half full) sets one clock after occupancy rises from 31 to 32 (`OC_PART→OC_HALF`). It stays clear at 31 entries.
- R9: `ev_rd` returns `ev_flags` in that cycle and clears every event bit at the edge. An event that sets at that same edge stays set.
- R10: `msk_wr` loads `msk_data` into the mask, where bit i=1 masks event bit i. `irq_n`=0 exactly when some event bit is 1 and its mask bit is 0.
- R11: After `ev_rd`, `irq_n` returns to 1 only if no unmasked event bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Deframer byte strobe |
| wr_data | input | 8 | Deframer byte |
| wr_open | input | 1 | Byte opens a frame |
| wr_close | input | 1 | Byte closes a frame |
| wr_ok | input | 1 | Closing frame is good |
| pop_rd | input | 1 | Host pops the head entry |
| fifo_empty | output | 1 | Queue holds no entry |
| hd_data | output | 8 | Head byte (0 when empty) |
| hd_open | output | 1 | Head open tag |
| hd_close | output | 1 | Head close tag |
| hd_ok | output | 1 | Head good-frame tag |
| ev_rd | input | 1 | Host reads and clears the event bits |
| ev_flags | output | 4 | Sticky events: 0 start, 1 end, 2 not empty, 3 half full |
| msk_wr | input | 1 | Mask register write strobe |
| msk_data | input | 4 | New mask value (1 = masked) |
| irq_n | output | 1 | Active-low interrupt |
| ovr_flag | output | 1 | Sticky overrun bit |

## Verification
The assertions check the following on every cycle:
- The occupancy never passes 64.
- An empty queue shows zeros and ignores pops.
- A write to a full queue raises the overrun bit.
- An accepted opening byte raises the start event.
- A low interrupt always has a set event behind it.
- The post-reset state is correct.

Only the bench scenarios can show these behaviours:
- Byte and tag order through the queue.
- The exact clock at which the level events appear, including the 31/32 boundary.
- That an event arriving in the same cycle as a clearing read survives and keeps the interrupt low.
- That the dropped byte really never reaches the head.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
    localparam int EV_N     = 4;
    localparam int EV_START = 0;
    localparam int EV_END   = 1;
    localparam int EV_NEMP  = 2;
    localparam int EV_HALF  = 3;

    typedef struct packed {
        logic open;
        logic close;
        logic ok;
    } hrf_tag_t;

    typedef enum logic [1:0] {
        OC_EMPTY = 2'd0,
        OC_PART  = 2'd1,
        OC_HALF  = 2'd2
    } hrf_occ_t;
endpackage

// File: rtl/hrf_store.sv
module hrf_store
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int EW   = DW + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  hrf_tag_t      wr_tag,
    input  logic          pop_rd,
    output logic [DW-1:0] hd_data,
    output hrf_tag_t      hd_tag,
    output logic          empty,
    output logic          wr_drop,
    output logic          wr_take,
    output logic [CW-1:0] occ
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == LAST_IX) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == FULL_CNT);
    assign empty   = (cnt_q == '0);
    assign wr_take = wr_valid && !full;
    assign wr_drop = wr_valid && full;
    assign do_pop  = pop_rd && !empty;
    assign occ     = cnt_q;

    always_ff @(posedge clk) begin
        if (wr_take) begin
            mem[wp_q] <= {wr_data, wr_tag};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_take) wp_q <= adv(wp_q);
            if (do_pop)  rp_q <= adv(rp_q);
            unique case ({wr_take, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        if (empty) begin
            hd_data = '0;
            hd_tag  = '0;
        end else begin
            {hd_data, hd_tag} = mem[rp_q];
        end
    end
endmodule

// File: rtl/hrf_occ_fsm.sv
module hrf_occ_fsm
    import hrf_pkg::*;
#(
    parameter int CW   = 7,
    parameter int HALF = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] occ,
    output logic          nemp_evt,
    output logic          half_evt
);
    localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

    hrf_occ_t state_q, state_d;

    always_comb begin
        if (occ == '0)             state_d = OC_EMPTY;
        else if (occ >= HALF_CNT)  state_d = OC_HALF;
        else                       state_d = OC_PART;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OC_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        nemp_evt = 1'b0;
        half_evt = 1'b0;
        unique case (state_q)
            OC_EMPTY: nemp_evt = (state_d != OC_EMPTY);
            OC_PART:  half_evt = (state_d == OC_HALF);
            OC_HALF:  ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hrf_events.sv
module hrf_events
    import hrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_N-1:0] ev_set,
    input  logic            ovr_set,
    input  logic            ev_rd,
    input  logic            msk_wr,
    input  logic [EV_N-1:0] msk_data,
    output logic [EV_N-1:0] ev_flags,
    output logic [EV_N-1:0] mask_q,
    output logic            ovr_flag,
    output logic            irq_n
);
    logic [EV_N-1:0] ev_q;
    logic            ovr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= '0;
            ovr_q  <= 1'b0;
            mask_q <= '1;
        end else begin
            ev_q  <= ev_rd ? ev_set  : (ev_q | ev_set);
            ovr_q <= ev_rd ? ovr_set : (ovr_q | ovr_set);
            if (msk_wr) mask_q <= msk_data;
        end
    end

    assign ev_flags = ev_q;
    assign ovr_flag = ovr_q;
    assign irq_n    = ~|(ev_q & ~mask_q);
endmodule

// File: rtl/hdlc_rx_tagfifo.sv
module hdlc_rx_tagfifo
    import hrf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_valid,
    input  logic [DW-1:0]   wr_data,
    input  logic            wr_open,
    input  logic            wr_close,
    input  logic            wr_ok,
    input  logic            pop_rd,
    output logic            fifo_empty,
    output logic [DW-1:0]   hd_data,
    output logic            hd_open,
    output logic            hd_close,
    output logic            hd_ok,
    input  logic            ev_rd,
    output logic [EV_N-1:0] ev_flags,
    input  logic            msk_wr,
    input  logic [EV_N-1:0] msk_data,
    output logic            irq_n,
    output logic            ovr_flag
);
    hrf_tag_t        in_tag, head_tag;
    logic            wr_drop, wr_take, nemp_evt, half_evt;
    logic [CW-1:0]   occ;
    logic [EV_N-1:0] ev_set, mask_q;

    assign in_tag = '{open: wr_open, close: wr_close, ok: wr_ok};

    hrf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(in_tag),
        .pop_rd(pop_rd),
        .hd_data(hd_data), .hd_tag(head_tag), .empty(fifo_empty),
        .wr_drop(wr_drop), .wr_take(wr_take), .occ(occ)
    );

    hrf_occ_fsm #(.CW(CW), .HALF(DEPTH / 2)) u_occ (
        .clk(clk), .rst(rst), .occ(occ),
        .nemp_evt(nemp_evt), .half_evt(half_evt)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_START] = wr_take && wr_open;
        ev_set[EV_END]   = wr_take && wr_close;
        ev_set[EV_NEMP]  = nemp_evt;
        ev_set[EV_HALF]  = half_evt;
    end

    hrf_events u_ev (
        .clk(clk), .rst(rst),
        .ev_set(ev_set), .ovr_set(wr_drop), .ev_rd(ev_rd),
        .msk_wr(msk_wr), .msk_data(msk_data),
        .ev_flags(ev_flags), .mask_q(mask_q),
        .ovr_flag(ovr_flag), .irq_n(irq_n)
    );

    assign hd_open  = head_tag.open;
    assign hd_close = head_tag.close;
    assign hd_ok    = head_tag.ok;
endmodule

// File: rtl/hrf_chk.sv
module hrf_chk #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          wr_open,
    input logic          pop_rd,
    input logic          fifo_empty,
    input logic [DW-1:0] hd_data,
    input logic          hd_open,
    input logic          hd_close,
    input logic          hd_ok,
    input logic [3:0]    ev_flags,
    input logic          irq_n,
    input logic          ovr_flag,
    input logic [CW-1:0] occ
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (fifo_empty && irq_n && ev_flags == 4'd0 && !ovr_flag));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> (hd_data == '0 && !hd_open && !hd_close && !hd_ok));

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && pop_rd && !wr_valid) |=> fifo_empty);

    // R5
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == FULL_CNT && wr_valid && !pop_rd) |=> (ovr_flag && occ == FULL_CNT));

    // R6
    start_event_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_open && occ < FULL_CNT) |=> ev_flags[0]);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (ev_flags != 4'd0));
endmodule

bind hdlc_rx_tagfifo hrf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_open(wr_open),
    .pop_rd(pop_rd), .fifo_empty(fifo_empty), .hd_data(hd_data),
    .hd_open(hd_open), .hd_close(hd_close), .hd_ok(hd_ok),
    .ev_flags(ev_flags), .irq_n(irq_n), .ovr_flag(ovr_flag), .occ(occ)
);

// File: tb/hdlc_rx_tagfifo_test.sv
module hdlc_rx_tagfifo_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0, wr_open = 1'b0, wr_close = 1'b0, wr_ok = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       pop_rd = 1'b0, ev_rd = 1'b0, msk_wr = 1'b0;
    logic [3:0] msk_data = 4'hF;
    logic       fifo_empty, hd_open, hd_close, hd_ok, irq_n, ovr_flag;
    logic [7:0] hd_data;
    logic [3:0] ev_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {data, open, close, ok}
    localparam logic [10:0] VEC [8] = '{
        {8'h7E, 3'b100}, {8'h11, 3'b000}, {8'hA5, 3'b000}, {8'h00, 3'b000},
        {8'hFF, 3'b011}, {8'h3C, 3'b100}, {8'hC3, 3'b000}, {8'h5A, 3'b010}
    };

    always #10 clk = ~clk;

    hdlc_rx_tagfifo uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_open(wr_open), .wr_close(wr_close), .wr_ok(wr_ok),
        .pop_rd(pop_rd), .fifo_empty(fifo_empty), .hd_data(hd_data),
        .hd_open(hd_open), .hd_close(hd_close), .hd_ok(hd_ok),
        .ev_rd(ev_rd), .ev_flags(ev_flags), .msk_wr(msk_wr),
        .msk_data(msk_data), .irq_n(irq_n), .ovr_flag(ovr_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] t);
        wr_valid = 1'b1; wr_data = d; {wr_open, wr_close, wr_ok} = t;
        tick();
        wr_valid = 1'b0; {wr_open, wr_close, wr_ok} = 3'b000;
    endtask

    task automatic pop();
        pop_rd = 1'b1; tick(); pop_rd = 1'b0;
    endtask

    task automatic evread();
        ev_rd = 1'b1; tick(); ev_rd = 1'b0;
    endtask

    task automatic setmask(input logic [3:0] m);
        msk_wr = 1'b1; msk_data = m; tick(); msk_wr = 1'b0;
    endtask

    initial begin
        int bad;
        idle(2);
        rst = 1'b0;
        // R1 reset state
        chk(fifo_empty == 1'b1, "R1", fifo_empty, 1);
        chk(ev_flags == 4'd0 && !ovr_flag, "R1", {ev_flags, ovr_flag}, 0);
        chk(irq_n == 1'b1, "R1", irq_n, 1);

        // R4 pop on empty
        pop();
        chk(fifo_empty && hd_data == 8'd0, "R4", {fifo_empty, hd_data}, 9'h100);

        // table: write all, then drain and compare (R2, R3)
        for (int i = 0; i < 8; i++) push(VEC[i][10:3], VEC[i][2:0]);
        idle(2);
        chk(ev_flags == 4'b0111, "R6", ev_flags, 4'b0111);
        chk(ev_flags[2] == 1'b1, "R7", ev_flags[2], 1);
        chk(irq_n == 1'b1, "R10", irq_n, 1);
        for (int i = 0; i < 8; i++) begin
            chk(hd_data == VEC[i][10:3], "R2", hd_data, VEC[i][10:3]);
            chk({hd_open, hd_close, hd_ok} == VEC[i][2:0], "R3",
                {hd_open, hd_close, hd_ok}, VEC[i][2:0]);
            pop();
        end
        chk(fifo_empty == 1'b1, "R4", fifo_empty, 1);

        // R9 read returns then clears
        ev_rd = 1'b1;
        @(posedge clk);
        chk(ev_flags == 4'b0111, "R9", ev_flags, 4'b0111);
        @(negedge clk);
        ev_rd = 1'b0;
        chk(ev_flags == 4'd0, "R9", ev_flags, 0);

        // R10 / R11 mask and release
        setmask(4'b1010);
        push(8'h21, 3'b000);
        idle(2);
        chk(ev_flags == 4'b0100, "R7", ev_flags, 4'b0100);
        chk(irq_n == 1'b0, "R10", irq_n, 0);
        ev_rd = 1'b1; wr_valid = 1'b1; wr_data = 8'h22; wr_open = 1'b1;
        tick();
        ev_rd = 1'b0; wr_valid = 1'b0; wr_open = 1'b0;
        chk(ev_flags == 4'b0001, "R9", ev_flags, 4'b0001);
        chk(irq_n == 1'b0, "R11", irq_n, 0);
        evread();
        chk(irq_n == 1'b1, "R11", irq_n, 1);
        pop(); pop();
        chk(fifo_empty == 1'b1, "R4", fifo_empty, 1);
        setmask(4'hF);
        evread();

        // R8 half boundary, R5 overrun
        for (int i = 0; i < 31; i++) push(8'(i), 3'b000);
        idle(2);
        chk(ev_flags[3] == 1'b0, "R8", ev_flags[3], 0);
        push(8'd31, 3'b000);
        chk(ev_flags[3] == 1'b0, "R8", ev_flags[3], 0);
        tick();
        chk(ev_flags[3] == 1'b1, "R8", ev_flags[3], 1);
        for (int i = 32; i < 64; i++) push(8'(i), 3'b000);
        chk(ovr_flag == 1'b0, "R5", ovr_flag, 0);
        push(8'hAA, 3'b111);
        chk(ovr_flag == 1'b1, "R5", ovr_flag, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (fifo_empty || hd_data != 8'(i)) bad++;
            pop();
        end
        chk(bad == 0, "R2", bad, 0);
        chk(fifo_empty == 1'b1, "R5", fifo_empty, 1);
        evread();
        chk(ovr_flag == 1'b0 && ev_flags == 4'd0, "R5", {ovr_flag, ev_flags}, 0);

        // R1 reset mid-traffic with masks open
        setmask(4'h0);
        push(8'h99, 3'b100);
        idle(2);
        chk(irq_n == 1'b0, "R10", irq_n, 0);
        rst = 1'b1; tick(); rst = 1'b0;
        chk(fifo_empty && irq_n && ev_flags == 4'd0, "R1",
            {fifo_empty, irq_n, ev_flags}, 6'b110000);
        push(8'h01, 3'b000);
        idle(2);
        chk(irq_n == 1'b1, "R1", irq_n, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule